// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a minimal one-address processor. It has one 16-bit accumulator, which is both the implied source and the destination of every data operation. Each instruction is one 16-bit word. The upper two bits select one of four operations. The lower fourteen bits give a direct word address into a 16K-word memory space. No other operand is encoded. Any intermediate result has to be stored to memory, because the core has no second data register.

The core talks to an external synchronous memory through one port. A read returns data one clock after the address is presented. A write is committed at the clock edge on which the write enable is high. Every instruction takes exactly three cycles:

- **Fetch:** the program counter drives the address.
- **Operand:** the address field of the word just returned drives the address.
- **Execute:** the accumulator is updated, or the accumulator is written to memory.

A halt input freezes the core at the next instruction boundary. The accumulator is brought out for observation.

Top module: `acc_core`

## Requirements
- R1: A synchronous active-high reset clears the program counter and the accumulator to zero. The first cycle after reset is a fetch from address 0, with the write enable low.
- R2: In the first cycle of every instruction, the memory address equals the program counter and the write enable is low.
- R3: In the second cycle, the memory address equals bits [13:0] of the instruction word returned by memory, and the write enable is low.
- R4: Opcode 00 (bits [15:14]) loads the addressed memory word into the accumulator. The new value is visible once the third cycle ends.
- R5: Opcode 01 raises the write enable only in the third cycle. In that cycle the address is the operand and the write data is the accumulator. The accumulator itself is left unchanged.
- R6: Opcode 10 sets the accumulator to accumulator plus memory word, modulo 2^16.
- R7: Opcode 11 sets the accumulator to accumulator minus memory word, modulo 2^16.
- R8: Every instruction takes exactly three cycles. The program counter grows by one per instruction and wraps from 16383 to 0.
- R9: The halt input is sampled only at an instruction boundary:
  - an instruction already under way completes;
  - while halted, the core keeps presenting the program counter, writes nothing and holds the accumulator;
  - it resumes with that fetch once halt drops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt | input | 1 | Stop at the next instruction boundary |
| mem_addr | output | 14 | Word address to memory |
| mem_wdata | output | 16 | Write data (accumulator) |
| mem_we | output | 1 | Write enable, one cycle per store |
| mem_rdata | input | 16 | Read data, valid one cycle after its address |
| acc_out | output | 16 | Current accumulator value |

## Verification
The results fall due at different cycles of each instruction:

- The fetch address is due in the same cycle as the instruction start.
- The operand address is due one edge later, because it is formed from the word that memory registered at the first edge.
- A store's write strobe and data are due in the third cycle.
- A new accumulator value appears only after the third edge.

The bench steps from one falling edge to the next through each instruction. It checks every output in the exact phase where that output is due. It computes the expected operand from its own memory model before any write in that phase lands. A halt is raised in mid-instruction to confirm the completion cycle and the frozen cycles that follow.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int unsigned WORD_W = 16;
    localparam int unsigned ADDR_W = 14;
    localparam int unsigned OP_W   = WORD_W - ADDR_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_ADD   = 2'b10,
        OP_SUB   = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_OPND  = 2'd1,
        PH_EXEC  = 2'd2
    } phase_e;

    typedef struct packed {
        op_e   op;
        addr_t addr;
    } instr_t;

    function automatic instr_t split_word(word_t w);
        instr_t r;
        r.op   = op_e'(w[WORD_W-1 -: OP_W]);
        r.addr = w[ADDR_W-1:0];
        return r;
    endfunction

    function automatic logic is_store(op_e op);
        return op == OP_STORE;
    endfunction

endpackage

// File: rtl/acc_seq.sv
module acc_seq
    import acc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   halt,
    output phase_e phase
);
    phase_e phase_d;

    always_comb begin
        case (phase)
            PH_FETCH: phase_d = halt ? PH_FETCH : PH_OPND;
            PH_OPND:  phase_d = PH_EXEC;
            PH_EXEC:  phase_d = PH_FETCH;
            default:  phase_d = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_FETCH;
        else     phase <= phase_d;
    end
endmodule

// File: rtl/acc_pc.sv
module acc_pc #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] pc
);
    always_ff @(posedge clk) begin
        if (rst)       pc <= '0;
        else if (step) pc <= pc + 1'b1;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  op_e          op,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] acc
);
    logic [W-1:0] acc_d;

    always_comb begin
        case (op)
            OP_LOAD: acc_d = opnd;
            OP_ADD:  acc_d = acc + opnd;
            OP_SUB:  acc_d = acc - opnd;
            default: acc_d = acc;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     acc <= '0;
        else if (en) acc <= acc_d;
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              halt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [WORD_W-1:0] acc_out
);
    phase_e phase_q;
    addr_t  pc_q;
    instr_t ir_q;
    instr_t fetched;
    word_t  acc_q;
    logic   exec_ph;
    logic   alu_en;

    acc_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .halt  (halt),
        .phase (phase_q)
    );

    assign exec_ph = (phase_q == PH_EXEC);

    acc_pc #(.W(ADDR_W)) u_pc (
        .clk  (clk),
        .rst  (rst),
        .step (exec_ph),
        .pc   (pc_q)
    );

    assign fetched = split_word(mem_rdata);

    always_ff @(posedge clk) begin
        if (rst)                    ir_q <= instr_t'('0);
        else if (phase_q == PH_OPND) ir_q <= fetched;
    end

    assign alu_en = exec_ph && !is_store(ir_q.op);

    acc_alu #(.W(WORD_W)) u_alu (
        .clk  (clk),
        .rst  (rst),
        .en   (alu_en),
        .op   (ir_q.op),
        .opnd (mem_rdata),
        .acc  (acc_q)
    );

    always_comb begin
        case (phase_q)
            PH_FETCH: mem_addr = pc_q;
            PH_OPND:  mem_addr = fetched.addr;
            PH_EXEC:  mem_addr = ir_q.addr;
            default:  mem_addr = pc_q;
        endcase
    end

    assign mem_we    = exec_ph && is_store(ir_q.op);
    assign mem_wdata = acc_q;
    assign acc_out   = acc_q;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
    import acc_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   halt,
    input logic   mem_we,
    input word_t  acc_out,
    input addr_t  pc,
    input phase_e phase,
    input op_e    ir_op
);
    // R1: reset leaves counter, accumulator and phase cleared
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (pc == '0 && acc_out == '0 && phase == PH_FETCH));

    // R5: the write strobe appears only in the execute phase
    p_write_exec_r5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> phase == PH_EXEC);

    // R5: a store leaves the accumulator untouched
    p_store_keeps_acc_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && ir_op == OP_STORE) |=> $stable(acc_out));

    // R8: the counter steps once per instruction, with wrap
    p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_EXEC |=> pc == addr_t'($past(pc) + 1'b1));

    // R8: the counter is still outside the execute phase
    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        phase != PH_EXEC |=> $stable(pc));

    // R8: three phases in order
    p_opnd_next_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_OPND |=> phase == PH_EXEC);
    p_exec_next_r8: assert property (@(posedge clk) disable iff (rst)
        phase == PH_EXEC |=> phase == PH_FETCH);

    // R9: halt at a boundary freezes counter and accumulator
    p_halt_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && halt) |=> (phase == PH_FETCH && $stable(pc) && $stable(acc_out)));

    // R9: without halt, a fetch moves on
    p_run_on_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH && !halt) |=> phase == PH_OPND);
endmodule

bind acc_core acc_core_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .halt    (halt),
    .mem_we  (mem_we),
    .acc_out (acc_out),
    .pc      (pc_q),
    .phase   (phase_q),
    .ir_op   (ir_q.op)
);

// File: tb/sim_acc_core.sv
module sim_acc_core;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt = 1'b0;
    logic [13:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_we;
    logic [15:0] mem_rdata;
    logic [15:0] acc_out;

    logic [15:0] mem [0:MEM_WORDS-1];

    int          n_checks = 0;
    int          n_errors = 0;
    logic [13:0] exp_pc  = '0;
    logic [15:0] exp_acc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_core u0 (
        .clk       (clk),
        .rst       (rst),
        .halt      (halt),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .acc_out   (acc_out)
    );

    // bench memory: registered read, read-before-write, aliased to 1K words
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_acc(input logic [1:0] op, input logic [15:0] a, input logic [15:0] m);
        case (op)
            2'b00:   return m;
            2'b10:   return a + m;
            2'b11:   return a - m;
            default: return a;
        endcase
    endfunction

    function automatic logic [15:0] mk(input logic [1:0] op, input logic [13:0] a);
        return {op, a};
    endfunction

    // one instruction, entered and left at a falling edge in the fetch phase
    task automatic run_instr(input bit halt_mid);
        logic [15:0] w;
        logic [15:0] opnd;
        chk(mem_addr == exp_pc, "R2 fetch address", mem_addr, exp_pc);
        chk(mem_we == 1'b0, "R2 fetch no write", mem_we, 0);
        w = mem[exp_pc[9:0]];
        @(negedge clk);
        chk(mem_addr == w[13:0], "R3 operand address", mem_addr, w[13:0]);
        chk(mem_we == 1'b0, "R3 operand no write", mem_we, 0);
        if (halt_mid) halt = 1'b1;
        @(negedge clk);
        opnd = mem[w[9:0]];
        if (w[15:14] == 2'b01) begin
            chk(mem_we == 1'b1, "R5 store strobe", mem_we, 1);
            chk(mem_addr == w[13:0], "R5 store address", mem_addr, w[13:0]);
            chk(mem_wdata == exp_acc, "R5 store data", mem_wdata, exp_acc);
        end else begin
            chk(mem_we == 1'b0, "R4 no write in execute", mem_we, 0);
        end
        exp_acc = model_acc(w[15:14], exp_acc, opnd);
        exp_pc  = exp_pc + 14'd1;
        @(negedge clk);
        case (w[15:14])
            2'b00: chk(acc_out == exp_acc, "R4 load result", acc_out, exp_acc);
            2'b01: chk(acc_out == exp_acc, "R5 acc kept on store", acc_out, exp_acc);
            2'b10: chk(acc_out == exp_acc, "R6 add result", acc_out, exp_acc);
            default: chk(acc_out == exp_acc, "R7 sub result", acc_out, exp_acc);
        endcase
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_pc  = '0;
        exp_acc = '0;
        chk(acc_out == 16'h0, "R1 acc cleared", acc_out, 0);
        chk(mem_addr == 14'h0, "R1 first fetch at 0", mem_addr, 0);
        chk(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd7315));
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'h0000;

        // directed: y = (r - d) + c, then wrap cases
        mem[0]  = mk(2'b00, 14'd600);
        mem[1]  = mk(2'b11, 14'd601 | 14'h2000);
        mem[2]  = mk(2'b01, 14'd602);
        mem[3]  = mk(2'b00, 14'd603);
        mem[4]  = mk(2'b10, 14'd602);
        mem[5]  = mk(2'b01, 14'd604 | 14'h3000);
        mem[6]  = mk(2'b00, 14'd605);
        mem[7]  = mk(2'b10, 14'd606);
        mem[8]  = mk(2'b11, 14'd606);
        mem[9]  = mk(2'b10, 14'd603);
        mem[10] = mk(2'b10, 14'd606);
        mem[600] = 16'd50;
        mem[601] = 16'd8;
        mem[603] = 16'd7;
        mem[605] = 16'hFFFF;
        mem[606] = 16'd1;

        @(negedge clk);
        do_reset();
        for (int k = 0; k < 9; k++) run_instr(1'b0);
        chk(mem[602] == 16'd42, "R5 stored temporary", mem[602], 42);
        chk(mem[604] == 16'd49, "R5 stored result", mem[604], 49);
        chk(acc_out == 16'hFFFF, "R7 sub wraps below zero", acc_out, 16'hFFFF);

        // halt raised mid-instruction: it completes, then the core freezes
        run_instr(1'b1);
        chk(acc_out == 16'd6, "R9 in-flight instruction completes", acc_out, 6);
        for (int k = 0; k < 5; k++) begin
            chk(mem_addr == exp_pc, "R9 halted address holds", mem_addr, exp_pc);
            chk(mem_we == 1'b0, "R9 halted no write", mem_we, 0);
            chk(acc_out == exp_acc, "R9 halted acc holds", acc_out, exp_acc);
            @(negedge clk);
        end
        halt = 1'b0;
        run_instr(1'b0);
        chk(acc_out == 16'd7, "R9 resumes after halt", acc_out, 7);

        // reset in the middle of a program
        run_instr(1'b0);
        do_reset();

        // random programs: code at 0..63, data at 512..1023 (aliased high bits)
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 64; i++) begin
                logic [13:0] a;
                a = {4'($urandom), 1'b1, 9'($urandom)};
                mem[i] = mk(2'($urandom), a);
            end
            for (int i = 512; i < MEM_WORDS; i++) mem[i] = 16'($urandom);
            if (p != 0) do_reset();
            for (int k = 0; k < 60; k++) run_instr(1'b0);
        end

        // program counter wrap: every word loads word 5
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = 16'h0005;
        do_reset();
        for (int k = 0; k < 16384; k++) run_instr(1'b0);
        chk(exp_pc == 14'd0, "R8 model wrapped", exp_pc, 0);
        chk(mem_addr == 14'd0, "R8 fetch address wraps to 0", mem_addr, 0);
        @(negedge clk);
        chk(mem_addr == 14'd5, "R8 three cycles per instruction", mem_addr, 5);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule